// File: doc/BRIEF.md
# Serial Adapter Bus Glue

This block sits between a 16-bit I/O bus and a single-channel synchronous serial controller. It claims an 8-byte window whose base is set by two switch banks. Each access in that window goes to one of three places: one of the controller's four ports, one of two on-board byte registers (communications and configuration), or reserved space. Accesses that miss the window complete at once and touch no state.

Bus accesses use a valid/ready handshake. The host holds `bus_valid`, `bus_we`, `bus_addr` and `bus_wdata` steady until it sees `bus_ready` high at a clock edge, and the access completes at that edge. `bus_ready` goes low only for a controller access that falls inside the recovery gap that follows the previous controller access. Read data is valid in the completing cycle. Every other access, whether a register, a reserved offset or a miss, completes in the cycle it is presented.

The configuration register picks the interrupt source. The interrupt pin is driven either as a shared open line, driven only while an interrupt is active, or as a dedicated line that is always driven. One bit of the communications register is also gated onto the controller's external sync input.

Top module: `sio_bus_glue`

## Requirements
- R1: `bus_hit` is high exactly when `bus_addr[15:8]` equals `base_hi_sw` and `bus_addr[7:3]` equals `base_lo_sw[4:0]`. `base_lo_sw[5]` has no effect.
- R2: Window offsets 0..3 address the controller. `scc_port` carries the offset (bit 1 = channel B, bit 0 = control port). `scc_cs` is high for exactly the one cycle in which such an access completes, with `scc_we`/`scc_wdata` following the bus, and the read data is taken from `scc_rdata`.
- R3: Offset 4 is the communications register and offset 5 is the configuration register. Both reset to 00h, and a written value reads back unchanged. `comm_o` mirrors the communications register.
- R4: Offsets 6 and 7 read as FFh. Writes to them change neither on-board register.
- R5: After a controller access completes with `recov_cycles` = N, the next controller access completes no earlier than N+1 cycles later. Accesses to on-board registers, reserved offsets or misses never wait, and they do not restart the gap.
- R6: Configuration bits [5:4] select the interrupt source: 00 = none, 01 = controller (`scc_irq`), 10 = terminal count, 11 = test mode. In test mode the request is configuration bit 6.
- R7: The interrupt state is registered and follows its inputs one clock later. With `share_en` high, `irq_oe` is high only while an interrupt is active, and `irq_o` is then 1. With `share_en` low, `irq_oe` is always 1 and `irq_o` equals the interrupt state.
- R8: A `dma_tc` pulse is latched only while `share_en` is high and source 10 is selected. The latch is cleared by a configuration write. If a configuration write and a `dma_tc` pulse fall in the same cycle, the latch ends up set.
- R9: `rlen_o` always equals communications bit 0. `scc_sync_a` equals that bit ANDed with `sync_link_en` and `scc_ext_sync`.
- R10: A read that misses the window returns 00h and completes with `bus_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_hi_sw | input | 8 | Base address bits 15..8 |
| base_lo_sw | input | 6 | Base address bits 7..3 in [4:0]; bit 5 unused |
| share_en | input | 1 | Shared (tri-state) interrupt mode |
| sync_link_en | input | 1 | Link from communications bit 0 to the sync input |
| recov_cycles | input | 4 | Idle clocks required between controller accesses |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Access completes this cycle |
| bus_we | input | 1 | 1 = write |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_ready |
| bus_hit | output | 1 | Address falls in the window |
| scc_cs | output | 1 | Controller access strobe |
| scc_we | output | 1 | Controller write |
| scc_port | output | 2 | Controller port select |
| scc_wdata | output | 8 | Controller write data |
| scc_rdata | input | 8 | Controller read data |
| scc_irq | input | 1 | Controller interrupt request |
| scc_ext_sync | input | 1 | Controller is in external sync mode |
| scc_sync_a | output | 1 | Controller external sync input |
| dma_tc | input | 1 | DMA terminal count pulse |
| comm_o | output | 8 | Communications register contents |
| rlen_o | output | 1 | Communications bit 0 |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
A configuration write clears the terminal-count latch, and a terminal-count pulse sets it, so the two can land on the same clock edge. The bench provokes this by presenting the configuration write and the `dma_tc` pulse in one cycle, with shared mode on and source 10 already selected. It then judges the outcome at the interrupt pin two cycles later, where the line must be driven active. A second overlap, a controller access waiting on its recovery gap while register accesses go through in between, is judged by counting the wait cycles.

// File: rtl/sio_glue_pkg.sv
package sio_glue_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_SCC  = 2'b01,
    SRC_TC   = 2'b10,
    SRC_TEST = 2'b11
  } irq_src_e;

  typedef enum logic [1:0] {
    RG_SCC  = 2'd0,
    RG_COMM = 2'd1,
    RG_CFG  = 2'd2,
    RG_RSV  = 2'd3
  } region_e;

  localparam int OFF_COMM   = 4;
  localparam int OFF_CFG    = 5;
  localparam int CFG_SRC_LO = 4;
  localparam int CFG_TEST   = 6;
  localparam int COMM_RLEN  = 0;
  localparam logic [7:0] RSV_READ = 8'hFF;
endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
  import sio_glue_pkg::*;
#(
  parameter int AW       = 16,
  parameter int WIN_BITS = 3,
  localparam int HI_W    = AW - 8,
  localparam int LO_W    = 8 - WIN_BITS
) (
  input  logic [AW-1:0]   addr,
  input  logic [HI_W-1:0] base_hi,
  input  logic [LO_W:0]   base_lo,
  output logic            hit,
  output region_e         region,
  output logic [1:0]      port
);
  logic [WIN_BITS-1:0] off;

  always_comb begin
    off  = addr[WIN_BITS-1:0];
    hit  = (addr[AW-1:8] == base_hi) && (addr[7:WIN_BITS] == base_lo[LO_W-1:0]);
    port = off[1:0];
    if (!off[2])                   region = RG_SCC;
    else if (int'(off) == OFF_COMM) region = RG_COMM;
    else if (int'(off) == OFF_CFG)  region = RG_CFG;
    else                            region = RG_RSV;
  end
endmodule

// File: rtl/sio_recov.sv
module sio_recov #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [CW-1:0] gap,
  output logic          grant
);
  logic [CW-1:0] cnt_q;

  assign grant = req && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (grant)         cnt_q <= gap;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  p_no_grant_in_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> !grant);
  p_gap_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (cnt_q == $past(gap)));
endmodule

// File: rtl/sio_irq_route.sv
module sio_irq_route
  import sio_glue_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_src_e sel,
  input  logic     test_req,
  input  logic     scc_irq,
  input  logic     dma_tc,
  input  logic     share_en,
  input  logic     cfg_wr,
  output logic     irq_o,
  output logic     irq_oe
);
  logic tc_flag_q;
  logic act_q;
  logic act_d;

  // set has priority over the clear from a configuration write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        tc_flag_q <= 1'b0;
    else if (dma_tc && share_en && sel == SRC_TC)      tc_flag_q <= 1'b1;
    else if (cfg_wr)                                   tc_flag_q <= 1'b0;
  end

  always_comb begin
    unique case (sel)
      SRC_SCC:  act_d = scc_irq;
      SRC_TC:   act_d = tc_flag_q;
      SRC_TEST: act_d = test_req;
      default:  act_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign irq_oe = share_en ? act_q : 1'b1;
  assign irq_o  = act_q;

  p_tc_needs_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag_q) |-> $past(share_en));
  p_shared_drives_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (share_en && irq_oe) |-> irq_o);
  p_active_has_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> ($past(sel) != SRC_NONE));
endmodule

// File: rtl/sio_bus_glue.sv
module sio_bus_glue
  import sio_glue_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int RCW = 4,
  localparam int HI_W = AW - 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] base_hi_sw,
  input  logic [5:0]      base_lo_sw,
  input  logic            share_en,
  input  logic            sync_link_en,
  input  logic [RCW-1:0]  recov_cycles,
  input  logic            bus_valid,
  output logic            bus_ready,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_hit,
  output logic            scc_cs,
  output logic            scc_we,
  output logic [1:0]      scc_port,
  output logic [DW-1:0]   scc_wdata,
  input  logic [DW-1:0]   scc_rdata,
  input  logic            scc_irq,
  input  logic            scc_ext_sync,
  output logic            scc_sync_a,
  input  logic            dma_tc,
  output logic [DW-1:0]   comm_o,
  output logic            rlen_o,
  output logic            irq_o,
  output logic            irq_oe
);
  region_e       region;
  logic          scc_req;
  logic          grant;
  logic          wr_acc;
  logic          cfg_wr;
  logic [DW-1:0] comm_q;
  logic [DW-1:0] cfg_q;

  sio_addr_decode #(.AW(AW), .WIN_BITS(3)) u_dec (
    .addr    (bus_addr),
    .base_hi (base_hi_sw),
    .base_lo (base_lo_sw),
    .hit     (bus_hit),
    .region  (region),
    .port    (scc_port)
  );

  assign scc_req = bus_valid && bus_hit && (region == RG_SCC);

  sio_recov #(.CW(RCW)) u_rec (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (scc_req),
    .gap   (recov_cycles),
    .grant (grant)
  );

  assign bus_ready = !scc_req || grant;
  assign scc_cs    = grant;
  assign scc_we    = bus_we;
  assign scc_wdata = bus_wdata;

  assign wr_acc = bus_valid && bus_hit && bus_we;
  assign cfg_wr = wr_acc && (region == RG_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comm_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_acc && region == RG_COMM) comm_q <= bus_wdata;
      if (cfg_wr)                      cfg_q  <= bus_wdata;
    end
  end

  always_comb begin
    if (!bus_hit) bus_rdata = '0;
    else begin
      unique case (region)
        RG_SCC:  bus_rdata = scc_rdata;
        RG_COMM: bus_rdata = comm_q;
        RG_CFG:  bus_rdata = cfg_q;
        default: bus_rdata = RSV_READ;
      endcase
    end
  end

  assign comm_o     = comm_q;
  assign rlen_o     = comm_q[COMM_RLEN];
  assign scc_sync_a = comm_q[COMM_RLEN] && sync_link_en && scc_ext_sync;

  sio_irq_route u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (irq_src_e'(cfg_q[CFG_SRC_LO +: 2])),
    .test_req (cfg_q[CFG_TEST]),
    .scc_irq  (scc_irq),
    .dma_tc   (dma_tc),
    .share_en (share_en),
    .cfg_wr   (cfg_wr),
    .irq_o    (irq_o),
    .irq_oe   (irq_oe)
  );

  p_region_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scc_cs |-> (bus_valid && bus_hit && !bus_addr[2]));
  p_rsv_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && region == RG_RSV) |=> ($stable(comm_q) && $stable(cfg_q)));
  p_stall_only_scc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> (bus_valid && bus_hit && region == RG_SCC));
  p_sync_implies_rlen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scc_sync_a |-> (rlen_o && sync_link_en));
  p_miss_no_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit |-> !scc_cs);
endmodule

// File: tb/sim_sio_bus_glue.sv
`timescale 1ns/1ps
module sim_sio_bus_glue;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  base_hi_sw = 8'h03;
  logic [5:0]  base_lo_sw = 6'h00;
  logic        share_en = 0, sync_link_en = 0, scc_irq = 0, scc_ext_sync = 0, dma_tc = 0;
  logic [3:0]  recov_cycles = 0;
  logic        bus_valid = 0, bus_we = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic        bus_ready, bus_hit, scc_cs, scc_we, scc_sync_a, rlen_o, irq_o, irq_oe;
  logic [1:0]  scc_port;
  logic [7:0]  bus_rdata, scc_wdata, scc_rdata, comm_o;

  int n_run = 0, n_fail = 0, cs_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // controller model: returns 50h + port
  assign scc_rdata = 8'h50 + {6'd0, scc_port};
  always @(posedge clk) if (scc_cs) cs_cnt++;

  sio_bus_glue u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  logic [7:0] x_rd; int x_wait; logic x_cs, x_we, x_hit; logic [1:0] x_port; logic [7:0] x_wd;

  task automatic xfer(input logic we, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    x_wait = 0;
    #1;
    while (!bus_ready && x_wait < 40) begin
      @(negedge clk); #1; x_wait++;
    end
    x_rd = bus_rdata; x_cs = scc_cs; x_we = scc_we; x_hit = bus_hit;
    x_port = scc_port; x_wd = scc_wdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_valid = 0;
    end
  endtask

  task automatic pulse_tc();
    @(negedge clk); bus_valid = 0; dma_tc = 1;
    @(negedge clk); dma_tc = 0;
  endtask

  // {we, offset[2:0], wdata[7:0], expected[7:0]}
  localparam logic [19:0] VEC [14] = '{
    {1'b1, 3'd4, 8'hA5, 8'h00},
    {1'b0, 3'd4, 8'h00, 8'hA5},
    {1'b1, 3'd5, 8'h3C, 8'h00},
    {1'b0, 3'd5, 8'h00, 8'h3C},
    {1'b1, 3'd6, 8'h77, 8'h00},
    {1'b0, 3'd6, 8'h00, 8'hFF},
    {1'b0, 3'd7, 8'h00, 8'hFF},
    {1'b0, 3'd4, 8'h00, 8'hA5},
    {1'b0, 3'd0, 8'h00, 8'h50},
    {1'b0, 3'd1, 8'h00, 8'h51},
    {1'b0, 3'd2, 8'h00, 8'h52},
    {1'b0, 3'd3, 8'h00, 8'h53},
    {1'b1, 3'd7, 8'h11, 8'h00},
    {1'b0, 3'd5, 8'h00, 8'h3C}
  };

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // reset state R3 R7 R9
    chk("R3 reset comm", comm_o, 8'h00);
    chk("R9 reset rlen", rlen_o, 1'b0);
    chk("R7 reset dedicated oe", irq_oe, 1'b1);
    chk("R7 reset irq", irq_o, 1'b0);
    chk("R2 reset cs", scc_cs, 1'b0);

    // vector table R2 R3 R4
    for (int i = 0; i < 14; i++) begin
      xfer(VEC[i][19], 16'h0300 | {13'd0, VEC[i][18:16]}, VEC[i][15:8]);
      if (!VEC[i][19]) chk($sformatf("R3/R4/R2 vec%0d rdata", i), x_rd, VEC[i][7:0]);
    end
    idle(1);
    chk("R2 cs count only for offsets 0-3", cs_cnt, 4);
    chk("R3 comm_o after table", comm_o, 8'hA5);

    // R2 controller write
    xfer(1, 16'h0302, 8'h9E);
    chk("R2 cs on write", x_cs, 1'b1);
    chk("R2 we", x_we, 1'b1);
    chk("R2 port", x_port, 2'd2);
    chk("R2 wdata", x_wd, 8'h9E);
    idle(1);

    // R1 / R10 window decode
    xfer(0, 16'h0308, 8'h00);
    chk("R1 miss hit", x_hit, 1'b0);
    chk("R10 miss no wait", x_wait, 0);
    chk("R10 miss rdata", x_rd, 8'h00);
    xfer(0, 16'h0B04, 8'h00);
    chk("R1 high byte miss", x_hit, 1'b0);
    base_lo_sw = 6'b100000;
    xfer(0, 16'h0304, 8'h00);
    chk("R1 sixth switch ignored", x_hit, 1'b1);
    chk("R1 sixth switch rdata", x_rd, 8'hA5);
    base_lo_sw = 6'h1F;
    xfer(0, 16'h03FC, 8'h00);
    chk("R1 base 3F8 hit", x_hit, 1'b1);
    chk("R1 base 3F8 rdata", x_rd, 8'hA5);
    base_lo_sw = 6'h00;
    idle(1);

    // R5 recovery
    recov_cycles = 4'd3;
    xfer(0, 16'h0300, 8'h00);
    chk("R5 first access no wait", x_wait, 0);
    xfer(0, 16'h0301, 8'h00);
    chk("R5 back-to-back waits N", x_wait, 3);
    chk("R5 read data after wait", x_rd, 8'h51);
    xfer(0, 16'h0304, 8'h00);
    chk("R5 register access no wait", x_wait, 0);
    xfer(0, 16'h0302, 8'h00);
    chk("R5 gap not restarted", x_wait, 2);
    idle(5);
    recov_cycles = 4'd0;
    xfer(0, 16'h0300, 8'h00);
    xfer(0, 16'h0303, 8'h00);
    chk("R5 zero gap back-to-back", x_wait, 0);
    idle(1);

    // R6 R7 interrupt source and pin mode
    scc_irq = 1;
    xfer(1, 16'h0305, 8'h10); idle(2);
    chk("R7 dedicated active irq_o", irq_o, 1'b1);
    chk("R7 dedicated oe", irq_oe, 1'b1);
    share_en = 1; idle(2);
    chk("R7 shared active oe", irq_oe, 1'b1);
    chk("R7 shared active irq_o", irq_o, 1'b1);
    scc_irq = 0; idle(2);
    chk("R7 shared idle floats", irq_oe, 1'b0);
    scc_irq = 1;
    xfer(1, 16'h0305, 8'h00); idle(2);
    chk("R6 source none", irq_oe, 1'b0);
    scc_irq = 0;
    xfer(1, 16'h0305, 8'h70); idle(2);
    chk("R6 test mode asserts", irq_oe, 1'b1);
    xfer(1, 16'h0305, 8'h30); idle(2);
    chk("R6 test mode bit clear", irq_oe, 1'b0);

    // R8 terminal count
    share_en = 0;
    xfer(1, 16'h0305, 8'h20); idle(1);
    pulse_tc(); idle(2);
    chk("R8 tc ignored in dedicated", irq_o, 1'b0);
    share_en = 1; idle(2);
    chk("R8 no latch from dedicated pulse", irq_oe, 1'b0);
    pulse_tc(); idle(2);
    chk("R8 tc latched shared", irq_oe, 1'b1);
    idle(3);
    chk("R8 tc latch holds", irq_oe, 1'b1);
    xfer(1, 16'h0305, 8'h20); idle(2);
    chk("R8 cfg write clears", irq_oe, 1'b0);
    // same cycle: cfg write and tc pulse
    @(negedge clk);
    bus_valid = 1; bus_we = 1; bus_addr = 16'h0305; bus_wdata = 8'h20; dma_tc = 1;
    @(negedge clk);
    bus_valid = 0; dma_tc = 0;
    idle(2);
    chk("R8 set wins over clear", irq_oe, 1'b1);
    xfer(1, 16'h0305, 8'h00); idle(2);
    share_en = 0;

    // R9 sync gating
    scc_ext_sync = 1; sync_link_en = 0;
    xfer(1, 16'h0304, 8'h01); idle(1); #1;
    chk("R9 rlen follows bit", rlen_o, 1'b1);
    chk("R9 no link no sync", scc_sync_a, 1'b0);
    sync_link_en = 1; #1;
    chk("R9 link and ext sync", scc_sync_a, 1'b1);
    scc_ext_sync = 0; #1;
    chk("R9 not ext sync mode", scc_sync_a, 1'b0);
    scc_ext_sync = 1;
    xfer(1, 16'h0304, 8'h00); idle(1); #1;
    chk("R9 bit cleared", scc_sync_a, 1'b0);
    chk("R9 rlen cleared", rlen_o, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule